// File: doc/BRIEF.md
# Unaligned Access Beat Splitter

This block takes a single byte-addressed write request and turns it into the bus beats needed to carry it on a data bus that is 32 or 64 bits wide. The request carries a byte address, a size code (one, two or four bytes) and up to four bytes of write data. Each beat it emits carries an address rounded down to the bus width, the request data moved onto the byte lanes it belongs to, and a byte-strobe mask that marks those lanes.

Only a request whose bytes run past the end of one bus word is split, and it then becomes exactly two beats. A request that is misaligned for its size but stays inside one bus word still takes a single beat. The misalignment is reported on a separate flag that travels with every beat. Requests enter through a valid/ready pair, and the block takes a new request only when the last beat of the previous one has been accepted. Beats leave through a second valid/ready pair.

Top module: `uas_splitter`

## Requirements
- R1: While reset is high and in the first cycle after it, `beat_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Its first beat is valid from the next cycle, and `req_ready` stays 0 for as long as any beat of that request is pending.
- R3: Size code 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes, and code 3 is handled as 4 bytes. `beat_aligned` is 1 when the request is aligned for its size: a 1-byte request always is, a 2-byte request needs address bit 0 clear, and a 4-byte request needs address bits 1:0 clear.
- R4: Strobe bit k enables lane k, which is bits 8k+7:8k of `beat_data`. With byte offset o (the address modulo the bus width in bytes B) and length n, the first beat enables lanes o through min(o+n, B)-1.
- R5: A request gives two beats exactly when o+n > B. Otherwise it gives one beat, and that beat has `beat_last` set.
- R6: The second beat enables lanes 0 through o+n-B-1. Its address is the first beat's address plus B, and `beat_last` is set on it.
- R7: The first beat's address is the request address with its low log2(B) bits cleared.
- R8: Request byte i (bits 8i+7:8i of `req_wdata`) is placed on lane o+i of the first beat when o+i < B. Otherwise it goes on lane o+i-B of the second beat. Every lane whose strobe is 0 carries zero.
- R9: While `beat_valid` is 1 and `beat_ready` is 0, the beat's address, data, strobe and last flag hold their values.
- R10: In the cycle after the final beat is accepted, `beat_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2 or 3=4 bytes |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Downstream takes the beat |
| beat_addr | output | ADDR_W | Bus-aligned beat address |
| beat_data | output | BUS_W | Lane-placed write data |
| beat_strb | output | BUS_W/8 | Byte-lane enables |
| beat_last | output | 1 | Final beat of the request |
| beat_aligned | output | 1 | Request aligned for its size |

## Verification
The bench tries every byte offset with every size code, both on a 32-bit bus and on a 64-bit bus. This covers the requests that are misaligned but do not cross a word boundary. A design that split on misalignment instead of on a boundary crossing would give a second beat there. A design that tested alignment against the bus width would clear `beat_aligned` on aligned halfword requests. Requests that cross a boundary are checked for the lanes that spill over. Here a wrong shift would put the overflow bytes on the top lanes instead of starting at lane 0, or leave the second address equal to the first. A stalled beat is held for several cycles with the downstream not ready, so a design that advanced or changed its outputs without the handshake shows up there.

// File: rtl/uas_pkg.sv
package uas_pkg;

    localparam int REQ_DATA_W = 32;
    localparam int REQ_BYTES  = REQ_DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_ONE  = 2'd0,
        SZ_TWO  = 2'd1,
        SZ_FOUR = 2'd2,
        SZ_WIDE = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_SECOND = 2'd2
    } seq_state_e;

    typedef struct packed {
        size_e                 size;
        logic [REQ_DATA_W-1:0] wdata;
    } payload_t;

    function automatic logic [2:0] size_bytes(input size_e s);
        case (s)
            SZ_ONE:  return 3'd1;
            SZ_TWO:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic size_aligned(input logic [1:0] low, input size_e s);
        case (s)
            SZ_ONE:  return 1'b1;
            SZ_TWO:  return ~low[0];
            default: return (low == 2'b00);
        endcase
    endfunction

endpackage

// File: rtl/uas_lane_map.sv
module uas_lane_map
    import uas_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic [$clog2(BUS_W/8)-1:0] ofs,
    input  payload_t                   pay,
    output logic [BUS_W/8-1:0]         lo_strb,
    output logic [BUS_W/8-1:0]         hi_strb,
    output logic [BUS_W-1:0]           lo_data,
    output logic [BUS_W-1:0]           hi_data,
    output logic                       split
);
    localparam int BYTES   = BUS_W / 8;
    localparam int OFS_W   = $clog2(BYTES);
    localparam int WSTRB_W = 2 * BYTES;
    localparam int WDATA_W = 2 * BUS_W;

    logic [2:0]            nbytes;
    logic [REQ_BYTES-1:0]  byte_on;
    logic [REQ_DATA_W-1:0] wd_masked;
    logic [WSTRB_W-1:0]    wide_strb;
    logic [WDATA_W-1:0]    wide_data;
    logic [OFS_W+2:0]      bit_shift;

    assign nbytes = size_bytes(pay.size);

    // one enable per request byte, and zero for bytes past the size
    for (genvar i = 0; i < REQ_BYTES; i++) begin : g_req_byte
        assign byte_on[i] = (3'(i) < nbytes);
        assign wd_masked[i*8 +: 8] = byte_on[i] ? pay.wdata[i*8 +: 8] : 8'h00;
    end

    assign bit_shift = {ofs, 3'b000};
    assign wide_strb = WSTRB_W'(byte_on) << ofs;
    assign wide_data = WDATA_W'(wd_masked) << bit_shift;

    assign lo_strb = wide_strb[BYTES-1:0];
    assign hi_strb = wide_strb[WSTRB_W-1:BYTES];
    assign lo_data = wide_data[BUS_W-1:0];
    assign hi_data = wide_data[WDATA_W-1:BUS_W];
    assign split   = |hi_strb;

endmodule

// File: rtl/uas_beat_seq.sv
module uas_beat_seq
    import uas_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  payload_t          req_pay,
    input  logic              beat_ready,
    input  logic              split,
    output logic              beat_valid,
    output logic              beat_second,
    output logic [ADDR_W-1:0] held_addr,
    output payload_t          held_pay
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE:   if (req_valid)  state_d = SEQ_FIRST;
            SEQ_FIRST:  if (beat_ready) state_d = split ? SEQ_SECOND : SEQ_IDLE;
            SEQ_SECOND: if (beat_ready) state_d = SEQ_IDLE;
            default:                    state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            held_addr <= '0;
            held_pay  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_IDLE && req_valid) begin
                held_addr <= req_addr;
                held_pay  <= req_pay;
            end
        end
    end

    assign req_ready   = (state_q == SEQ_IDLE);
    assign beat_valid  = (state_q != SEQ_IDLE);
    assign beat_second = (state_q == SEQ_SECOND);

endmodule

// File: rtl/uas_splitter.sv
module uas_splitter
    import uas_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic [31:0]          req_wdata,
    output logic                 beat_valid,
    input  logic                 beat_ready,
    output logic [ADDR_W-1:0]    beat_addr,
    output logic [BUS_W-1:0]     beat_data,
    output logic [BUS_W/8-1:0]   beat_strb,
    output logic                 beat_last,
    output logic                 beat_aligned
);
    localparam int BYTES = BUS_W / 8;
    localparam int OFS_W = $clog2(BYTES);

    payload_t          in_pay, held_pay;
    logic [ADDR_W-1:0] held_addr, base_addr;
    logic              beat_second, split;
    logic [BYTES-1:0]  lo_strb, hi_strb;
    logic [BUS_W-1:0]  lo_data, hi_data;

    assign in_pay.size  = size_e'(req_size);
    assign in_pay.wdata = req_wdata;

    uas_beat_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_pay     (in_pay),
        .beat_ready  (beat_ready),
        .split       (split),
        .beat_valid  (beat_valid),
        .beat_second (beat_second),
        .held_addr   (held_addr),
        .held_pay    (held_pay)
    );

    uas_lane_map #(.BUS_W(BUS_W)) u_map (
        .ofs     (held_addr[OFS_W-1:0]),
        .pay     (held_pay),
        .lo_strb (lo_strb),
        .hi_strb (hi_strb),
        .lo_data (lo_data),
        .hi_data (hi_data),
        .split   (split)
    );

    assign base_addr    = {held_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign beat_addr    = beat_second ? base_addr + ADDR_W'(BYTES) : base_addr;
    assign beat_strb    = beat_second ? hi_strb : lo_strb;
    assign beat_data    = beat_second ? hi_data : lo_data;
    assign beat_last    = beat_second | ~split;
    assign beat_aligned = size_aligned(held_addr[1:0], held_pay.size);

endmodule

// File: rtl/uas_checker.sv
module uas_checker #(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               beat_valid,
    input logic               beat_ready,
    input logic [ADDR_W-1:0]  beat_addr,
    input logic [BUS_W-1:0]   beat_data,
    input logic [BUS_W/8-1:0] beat_strb,
    input logic               beat_last
);
    localparam int BYTES = BUS_W / 8;
    localparam int OFS_W = $clog2(BYTES);

    logic [BUS_W-1:0] lane_bits;
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign lane_bits[i*8 +: 8] = {8{beat_strb[i]}};
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!beat_valid && req_ready));

    a_r2_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> !req_ready);

    a_r2_accept_beat: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> beat_valid);

    a_r4_strobe_present: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (beat_strb != '0));

    a_r6_second_beat: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && !beat_last) |=>
        (beat_valid && beat_last && beat_strb[0] &&
         beat_addr == $past(beat_addr) + ADDR_W'(BYTES)));

    a_r7_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (beat_addr[OFS_W-1:0] == '0));

    a_r8_idle_lanes_zero: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> ((beat_data & ~lane_bits) == '0));

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=>
        (beat_valid && $stable(beat_addr) && $stable(beat_data) &&
         $stable(beat_strb) && $stable(beat_last)));

    a_r10_release: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && beat_last) |=> (!beat_valid && req_ready));

endmodule

bind uas_splitter uas_checker #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_data  (beat_data),
    .beat_strb  (beat_strb),
    .beat_last  (beat_last)
);

// File: tb/tb_uas_splitter.sv
module tb_uas_splitter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        n_bready = 1'b1, w_bready = 1'b1;

    logic        n_rready, n_valid, n_last, n_al;
    logic [31:0] n_addr, n_data;
    logic [3:0]  n_strb;
    logic        w_rready, w_valid, w_last, w_al;
    logic [31:0] w_addr;
    logic [63:0] w_data;
    logic [7:0]  w_strb;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uas_splitter #(.ADDR_W(32), .BUS_W(32)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(n_rready),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .beat_valid(n_valid), .beat_ready(n_bready), .beat_addr(n_addr),
        .beat_data(n_data), .beat_strb(n_strb), .beat_last(n_last),
        .beat_aligned(n_al)
    );

    uas_splitter #(.ADDR_W(32), .BUS_W(64)) dut_w (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(w_rready),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .beat_valid(w_valid), .beat_ready(w_bready), .beat_addr(w_addr),
        .beat_data(w_data), .beat_strb(w_strb), .beat_last(w_last),
        .beat_aligned(w_al)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference built from the requirements (R3..R8)
    task automatic model(input int bw, input logic [31:0] a, input logic [1:0] sz,
                         input logic [31:0] wd,
                         output logic [7:0] s1, output logic [7:0] s2,
                         output logic [63:0] d1, output logic [63:0] d2,
                         output bit sp, output logic [31:0] a1,
                         output logic [31:0] a2, output bit al);
        int n, off;
        n   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        off = int'(a % bw);
        s1 = '0; s2 = '0; d1 = '0; d2 = '0;
        for (int k = 0; k < n; k++) begin
            if (off + k < bw) begin
                s1[off+k] = 1'b1;
                d1[(off+k)*8 +: 8] = wd[k*8 +: 8];
            end else begin
                s2[off+k-bw] = 1'b1;
                d2[(off+k-bw)*8 +: 8] = wd[k*8 +: 8];
            end
        end
        sp = (off + n > bw);
        a1 = a - 32'(off);
        a2 = a1 + 32'(bw);
        al = ((a % n) == 0);
    endtask

    task automatic chk_beat(input string who, input string at, input string st,
                            input logic v, input logic [31:0] ad,
                            input logic [7:0] sb, input logic [63:0] dt,
                            input logic la, input logic al,
                            input logic [31:0] ead, input logic [7:0] esb,
                            input logic [63:0] edt, input logic ela,
                            input logic eal);
        chk(v == 1'b1, {"R2 valid ", who}, 64'(v), 64'd1);
        chk(ad == ead, {at, " addr ", who}, 64'(ad), 64'(ead));
        chk(sb == esb, {st, " strb ", who}, 64'(sb), 64'(esb));
        chk(dt == edt, {"R8 data ", who}, dt, edt);
        chk(la == ela, {"R5 last ", who}, 64'(la), 64'(ela));
        chk(al == eal, {"R3 aligned ", who}, 64'(al), 64'(eal));
    endtask

    task automatic run_one(input logic [31:0] a, input logic [1:0] sz,
                           input logic [31:0] wd);
        logic [7:0]  ns1, ns2, ws1, ws2;
        logic [63:0] nd1, nd2, wd1, wd2;
        logic [31:0] na1, na2, wa1, wa2;
        bit nsp, wsp, nal, wal;
        model(4, a, sz, wd, ns1, ns2, nd1, nd2, nsp, na1, na2, nal);
        model(8, a, sz, wd, ws1, ws2, wd1, wd2, wsp, wa1, wa2, wal);
        @(negedge clk);
        n_bready = 1'b1; w_bready = 1'b1;
        req_valid = 1'b1; req_addr = a; req_size = sz; req_wdata = wd;
        chk(n_rready && w_rready, "R2 ready before request", 64'({n_rready, w_rready}), 64'd3);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!n_rready && !w_rready, "R2 busy while beat pending", 64'({n_rready, w_rready}), 64'd0);
        chk_beat("bus32 first", "R7", "R4", n_valid, n_addr, {4'b0, n_strb}, {32'b0, n_data},
                 n_last, n_al, na1, ns1, nd1, !nsp, nal);
        chk_beat("bus64 first", "R7", "R4", w_valid, w_addr, w_strb, w_data,
                 w_last, w_al, wa1, ws1, wd1, !wsp, wal);
        @(negedge clk);
        if (nsp)
            chk_beat("bus32 second", "R6", "R6", n_valid, n_addr, {4'b0, n_strb}, {32'b0, n_data},
                     n_last, n_al, na2, ns2, nd2, 1'b1, nal);
        else
            chk(!n_valid && n_rready, "R5 single beat bus32", 64'({n_valid, n_rready}), 64'd1);
        if (wsp)
            chk_beat("bus64 second", "R6", "R6", w_valid, w_addr, w_strb, w_data,
                     w_last, w_al, wa2, ws2, wd2, 1'b1, wal);
        else
            chk(!w_valid && w_rready, "R5 single beat bus64", 64'({w_valid, w_rready}), 64'd1);
        @(negedge clk);
        chk(!n_valid && n_rready && !w_valid && w_rready, "R10 idle after last beat",
            64'({n_valid, n_rready, w_valid, w_rready}), 64'b0101);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!n_valid && n_rready, "R1 bus32 in reset", 64'({n_valid, n_rready}), 64'd1);
        chk(!w_valid && w_rready, "R1 bus64 in reset", 64'({w_valid, w_rready}), 64'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(!n_valid && n_rready && !w_valid && w_rready, "R1 after reset",
            64'({n_valid, n_rready, w_valid, w_rready}), 64'b0101);
    endtask

    task automatic t_sweep;
        for (int off = 0; off < 8; off++) begin
            for (int sz = 0; sz < 4; sz++) begin
                run_one(32'h0000_2000 + 32'(off), 2'(sz),
                        32'hA1B2_C3D4 ^ (32'(off) * 32'h0101_0101) ^ 32'(sz << 4));
            end
        end
    endtask

    task automatic t_examples;
        // bus64: 4 bytes at 0x1001 stay in lanes 1..4; bus32 splits them
        run_one(32'h0000_1001, 2'd2, 32'h4433_2211);
        chk(1'b1, "R5 middle lanes case", 64'd0, 64'd0);
        // 4 bytes at 0x48E cross both widths: 0xC/0x3 on bus32, 0xC0/0x03 on bus64
        run_one(32'h0000_048E, 2'd2, 32'hDDCC_BBAA);
        // halfword aligned for size but not for bus
        run_one(32'h0000_0016, 2'd1, 32'h0000_BEEF);
        // halfword at the last lane of the 64-bit word
        run_one(32'h0000_0037, 2'd1, 32'h0000_1234);
    endtask

    task automatic t_stall;
        logic [31:0] na, wa;
        logic [31:0] nd;
        logic [63:0] wdv;
        logic [3:0]  ns;
        logic [7:0]  ws;
        @(negedge clk);
        n_bready = 1'b0; w_bready = 1'b0;
        req_valid = 1'b1; req_addr = 32'h0000_3003; req_size = 2'd2; req_wdata = 32'h5566_7788;
        @(negedge clk);
        req_valid = 1'b0;
        na = n_addr; nd = n_data; ns = n_strb; wa = w_addr; wdv = w_data; ws = w_strb;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(n_valid && n_addr == na && n_data == nd && n_strb == ns && !n_last,
                "R9 bus32 held", 64'({n_addr, n_data}), 64'({na, nd}));
            chk(w_valid && w_addr == wa && w_data == wdv && w_strb == ws && w_last,
                "R9 bus64 held", 64'(w_data), wdv);
        end
        n_bready = 1'b1; w_bready = 1'b1;
        @(negedge clk);
        chk(n_valid && n_last && n_strb == 4'h7 && n_addr == 32'h0000_3004,
            "R6 bus32 second after stall", 64'({n_addr, 4'b0, n_strb}), 64'({32'h3004, 8'h07}));
        chk(!w_valid && w_rready, "R10 bus64 released", 64'({w_valid, w_rready}), 64'd1);
        @(negedge clk);
        chk(!n_valid && n_rready, "R10 bus32 released", 64'({n_valid, n_rready}), 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_sweep();
        t_examples();
        t_stall();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule